// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a calendar clock that presents itself as the eight highest byte locations of a byte-wide memory space. A host reaches it with the usual asynchronous SRAM handshake: active-low chip-enable, output-enable and write-enable, an address bus and separate data-in and data-out buses. A data-out enable tells the surrounding pad logic when to drive. The time is held as packed BCD: century, year, month, date, day-of-week, hour, minute and second. Bits in those bytes that carry no clock field work as plain storage.

A tick input prescaled by `TICKS_PER_SEC` advances the seconds. Carries ripple through the chain up to the century. The date wraps by month length, with a 29th of February in years divisible by four. The control bits are packed into the clock bytes. A stop bit halts counting. A frequency-test bit drives a square wave at the once-per-second rate. A read-hold bit freezes the copy the bus sees. A write-hold bit suspends counting and stages new clock values, which are loaded as a whole when the bit is cleared. A battery-flag input shows up as a read-only bit.

The bus strobes are sampled on the system clock. A write commits on the first clock edge after the write phase ends. It uses the address and data from the last clock in which chip-enable and write-enable were both low.

Top module: `calClockTop`

## Requirements
- R1: Only addresses whose upper bits are all ones hit the block. The low three address bits select the byte: 7 year, 6 month, 5 date, 4 day, 3 hour, 2 minutes, 1 seconds, 0 century/control. Reads of any other address leave `dataOe` low.
- R2: `dataOe` is high exactly when `ceN` and `oeN` are low, `weN` is high and the address hits. `dataOut` then follows the address combinationally.
- R3: A write commits on the first rising clock edge after `ceN` or `weN` has gone high. It uses the address and data sampled in the last clock cycle where both were low, and ignores data present after the write phase ended.
- R4: While `weN` is low, `dataOe` is low whatever `oeN` is.
- R5: Spare bits store and return what was written, and writes to them are accepted at all times: month bits 7:5, date bits 7:6, day bits 5:3, hour bits 7:6, minute bit 7. Day bit 7 always reads as `batFlag`, and writes to it have no effect.
- R6: Seconds advance by one every `TICKS_PER_SEC` accepted ticks. Seconds and minutes wrap 59 to 00 and hours wrap 23 to 00, each carrying into the next field.
- R7: At each hour wrap the day-of-week (bits 2:0 of the day byte) goes from 07 to 01, and otherwise increments. The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 either 29 (year divisible by four) or 28.
- R8: Month wraps 12 to 01 and carries into the year. The year wraps 99 to 00 and carries into the century, which wraps 39 to 00.
- R9: While the stop bit (seconds bit 7) is set, ticks have no effect on the time or the prescaler.
- R10: While the write-hold bit (control byte bit 7) is set, counting is suspended and writes to clock fields are staged. When the bit is written to 0, the staged values are loaded into the counters, and the century comes from that same write. Clock-field writes made while the bit is clear are ignored.
- R11: While the read-hold bit (control byte bit 6) is set, the clock fields seen on the bus stay frozen while counting continues. After the bit is cleared, reads show the live time.
- R12: `freqOut` is high for the first `TICKS_PER_SEC/2` prescaler states of each second when the frequency-test bit (day bit 6) is set and the stop bit is clear. Otherwise it is low.
- R13: After reset the time reads century 00, year 00, month 01, date 01, day 01, 00:00:00, with all control and spare bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler pulse, one clock wide |
| batFlag | input | 1 | Battery flag, shown as day bit 7 |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, zero when not driving |
| dataOe | output | 1 | Read data bus drive enable |
| freqOut | output | 1 | Frequency-test square wave |

## Verification
Several rules are checked on every cycle: the data bus is released while write-enable is low, and the time never changes without an accepted tick or a committed write. Likewise, neither a set stop bit nor a set write-hold bit lets the live time move, and a held read copy stays still. The calendar arithmetic can only be shown by the bench's scenarios. These cover month-length and leap-year rollover swept over every month of several years, the century wrap, a long run of seconds, staging and loading under write hold, write capture at the end of the write phase, and the spare and read-only bits.

// File: rtl/calPkg.sv
package calPkg;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
    logic [5:0] cent;
  } calTime_t;

  typedef struct packed {
    logic       commit;
    logic [2:0] off;
    logic [7:0] data;
  } busStrobe_t;

  localparam logic [2:0] OFF_CENT  = 3'd0;
  localparam logic [2:0] OFF_SEC   = 3'd1;
  localparam logic [2:0] OFF_MIN   = 3'd2;
  localparam logic [2:0] OFF_HOUR  = 3'd3;
  localparam logic [2:0] OFF_DAY   = 3'd4;
  localparam logic [2:0] OFF_DATE  = 3'd5;
  localparam logic [2:0] OFF_MONTH = 3'd6;
  localparam logic [2:0] OFF_YEAR  = 3'd7;

  localparam calTime_t TIME_RST = '{year: 8'h00, month: 5'h01, date: 6'h01,
                                    day: 3'h1, hour: 6'h00, min: 7'h00,
                                    sec: 7'h00, cent: 6'h00};

  function automatic logic [6:0] bcdVal(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] monthLen(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] m;
    logic [6:0] y;
    m = bcdVal({3'b000, mon});
    y = bcdVal(yr);
    case (m)
      7'd2:                       return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  // one-second advance of the whole calendar chain
  function automatic calTime_t stepTime(input calTime_t t);
    calTime_t r;
    r = t;
    if (bcdVal({1'b0, t.sec}) >= 7'd59) begin
      r.sec = 7'h00;
      if (bcdVal({1'b0, t.min}) >= 7'd59) begin
        r.min = 7'h00;
        if (bcdVal({2'b00, t.hour}) >= 7'd23) begin
          r.hour = 6'h00;
          r.day  = (t.day >= 3'd7 || t.day == 3'd0) ? 3'd1 : t.day + 3'd1;
          if (bcdVal({2'b00, t.date}) >= monthLen(t.month, t.year)) begin
            r.date = 6'h01;
            if (bcdVal({3'b000, t.month}) >= 7'd12) begin
              r.month = 5'h01;
              if (bcdVal(t.year) >= 7'd99) begin
                r.year = 8'h00;
                r.cent = (bcdVal({2'b00, t.cent}) >= 7'd39) ? 6'h00
                         : 6'(toBcd(bcdVal({2'b00, t.cent}) + 7'd1));
              end else begin
                r.year = toBcd(bcdVal(t.year) + 7'd1);
              end
            end else begin
              r.month = 5'(toBcd(bcdVal({3'b000, t.month}) + 7'd1));
            end
          end else begin
            r.date = 6'(toBcd(bcdVal({2'b00, t.date}) + 7'd1));
          end
        end else begin
          r.hour = 6'(toBcd(bcdVal({2'b00, t.hour}) + 7'd1));
        end
      end else begin
        r.min = 7'(toBcd(bcdVal({1'b0, t.min}) + 7'd1));
      end
    end else begin
      r.sec = 7'(toBcd(bcdVal({1'b0, t.sec}) + 7'd1));
    end
    return r;
  endfunction

endpackage

// File: rtl/calBusCtrl.sv
module calBusCtrl
  import calPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output busStrobe_t        strb,
  output logic [2:0]        rdOff,
  output logic              dataOe
);

  localparam int HI_W = ADDR_W - 3;

  logic              wrAct;
  logic              wrActQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              rdHit;
  logic              wrHitQ;

  assign wrAct  = !ceN && !weN;
  assign rdHit  = &addr[ADDR_W-1:ADDR_W-HI_W];
  assign wrHitQ = &addrQ[ADDR_W-1:ADDR_W-HI_W];
  assign rdOff  = addr[2:0];
  assign dataOe = !ceN && !oeN && weN && rdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      addrQ  <= '0;
      dataQ  <= '0;
    end else begin
      wrActQ <= wrAct;
      if (wrAct) begin
        addrQ <= addr;
        dataQ <= dataIn;
      end
    end
  end

  always_comb begin
    strb.commit = wrActQ && !wrAct && wrHitQ;
    strb.off    = addrQ[2:0];
    strb.data   = dataQ;
  end

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
#(
  parameter int TICKS_PER_SEC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       batFlag,
  input  busStrobe_t strb,
  input  logic [2:0] rdOff,
  output logic [7:0] rdByte,
  output logic       freqOut,
  output calTime_t   liveTime,
  output calTime_t   visTime,
  output logic       stopBit,
  output logic       wHold,
  output logic       rHold
);

  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(TICKS_PER_SEC / 2);

  calTime_t   live, stage, snap, loadVal;
  logic [SUB_W-1:0] subCnt;
  logic [2:0] spMonth, spDay;
  logic [1:0] spDate, spHour;
  logic       spMin, ftBit;
  logic       tickEn, secStep, loadLive, isCent;

  assign tickEn   = tick && !stopBit && !wHold;
  assign secStep  = tickEn && (subCnt == SUB_LAST);
  assign isCent   = strb.commit && (strb.off == OFF_CENT);
  assign loadLive = isCent && wHold && !strb.data[7];

  always_comb begin
    loadVal      = stage;
    loadVal.cent = strb.data[5:0];
  end

  // live counters and prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live   <= TIME_RST;
      snap   <= TIME_RST;
      subCnt <= '0;
    end else begin
      if (secStep)       live <= stepTime(live);
      else if (loadLive) live <= loadVal;
      if (!rHold) snap <= live;
      if (tickEn) subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + SUB_W'(1);
    end
  end

  // byte writes: control, spare and staged clock fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage   <= TIME_RST;
      spMonth <= '0;
      spDate  <= '0;
      spDay   <= '0;
      spHour  <= '0;
      spMin   <= 1'b0;
      ftBit   <= 1'b0;
      stopBit <= 1'b0;
      wHold   <= 1'b0;
      rHold   <= 1'b0;
    end else if (strb.commit) begin
      case (strb.off)
        OFF_YEAR: begin
          if (wHold) stage.year <= strb.data;
        end
        OFF_MONTH: begin
          spMonth <= strb.data[7:5];
          if (wHold) stage.month <= strb.data[4:0];
        end
        OFF_DATE: begin
          spDate <= strb.data[7:6];
          if (wHold) stage.date <= strb.data[5:0];
        end
        OFF_DAY: begin
          ftBit <= strb.data[6];
          spDay <= strb.data[5:3];
          if (wHold) stage.day <= strb.data[2:0];
        end
        OFF_HOUR: begin
          spHour <= strb.data[7:6];
          if (wHold) stage.hour <= strb.data[5:0];
        end
        OFF_MIN: begin
          spMin <= strb.data[7];
          if (wHold) stage.min <= strb.data[6:0];
        end
        OFF_SEC: begin
          stopBit <= strb.data[7];
          if (wHold) stage.sec <= strb.data[6:0];
        end
        default: begin
          wHold <= strb.data[7];
          rHold <= strb.data[6];
          if (wHold) stage.cent <= strb.data[5:0];
          else if (strb.data[7]) stage <= live;
        end
      endcase
    end
  end

  assign visTime  = rHold ? snap : live;
  assign liveTime = live;
  assign freqOut  = ftBit && !stopBit && (subCnt < SUB_HALF);

  always_comb begin
    case (rdOff)
      OFF_YEAR:  rdByte = visTime.year;
      OFF_MONTH: rdByte = {spMonth, visTime.month};
      OFF_DATE:  rdByte = {spDate, visTime.date};
      OFF_DAY:   rdByte = {batFlag, ftBit, spDay, visTime.day};
      OFF_HOUR:  rdByte = {spHour, visTime.hour};
      OFF_MIN:   rdByte = {spMin, visTime.min};
      OFF_SEC:   rdByte = {stopBit, visTime.sec};
      default:   rdByte = {wHold, rHold, visTime.cent};
    endcase
  end

endmodule

// File: rtl/calClockTop.sv
module calClockTop
  import calPkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TICKS_PER_SEC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              batFlag,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              freqOut
);

  busStrobe_t strb;
  logic [2:0] rdOff;
  logic [7:0] rdByte;
  calTime_t   liveTime, visTime;
  logic       stopBit, wHold, rHold;

  calBusCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .strb(strb), .rdOff(rdOff), .dataOe(dataOe)
  );

  calDatapath #(.TICKS_PER_SEC(TICKS_PER_SEC)) dp (
    .clk(clk), .rstN(rstN), .tick(tick), .batFlag(batFlag), .strb(strb),
    .rdOff(rdOff), .rdByte(rdByte), .freqOut(freqOut), .liveTime(liveTime),
    .visTime(visTime), .stopBit(stopBit), .wHold(wHold), .rHold(rHold)
  );

  assign dataOut = dataOe ? rdByte : 8'h00;

endmodule

// File: rtl/calClockChk.sv
module calClockChk
  import calPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     weN,
  input logic     dataOe,
  input logic     tick,
  input logic     commit,
  input logic     stopBit,
  input logic     wHold,
  input logic     rHold,
  input calTime_t liveTime,
  input calTime_t visTime
);

  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !dataOe);

  // R6
  no_spurious_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !commit) |=> $stable(liveTime));

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !commit) |=> $stable(liveTime));

  // R10
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wHold && !commit) |=> $stable(liveTime));

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rHold && !commit) |=> $stable(visTime));

endmodule

bind calClockTop calClockChk chk (
  .clk(clk), .rstN(rstN), .weN(weN), .dataOe(dataOe), .tick(tick),
  .commit(strb.commit), .stopBit(stopBit), .wHold(wHold), .rHold(rHold),
  .liveTime(liveTime), .visTime(visTime)
);

// File: tb/calClockTop_test.sv
module calClockTop_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 2;
  localparam int AW         = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          batFlag = 1'b0;
  logic          ceN = 1'b1;
  logic          oeN = 1'b1;
  logic          weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataOe;
  logic          freqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  calClockTop #(.ADDR_W(AW), .TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .batFlag(batFlag), .ceN(ceN),
    .oeN(oeN), .weN(weN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .freqOut(freqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int daysOf(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic busWrite(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    addr = {5'h1F, off}; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [2:0] off, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = {5'h1F, off}; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1;
    d = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic readChk(input string tag, input logic [2:0] off, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    busRead(off, d, oe);
    check(tag, d, exp);
  endtask

  task automatic tickOnce();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic second();
    for (int i = 0; i < TPS; i++) tickOnce();
  endtask

  task automatic setTime(input logic [7:0] ce, input logic [7:0] yr, input logic [7:0] mo,
                         input logic [7:0] dt, input logic [7:0] dy, input logic [7:0] hr,
                         input logic [7:0] mi, input logic [7:0] se);
    busWrite(3'd0, 8'h80);
    busWrite(3'd7, yr);
    busWrite(3'd6, mo);
    busWrite(3'd5, dt);
    busWrite(3'd4, dy);
    busWrite(3'd3, hr);
    busWrite(3'd2, mi);
    busWrite(3'd1, se);
    busWrite(3'd0, {2'b00, ce[5:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int yrs[4];
    int y, m, dd;
    yrs[0] = 0; yrs[1] = 1; yrs[2] = 4; yrs[3] = 99;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state
    readChk("R13 cent", 3'd0, 8'h00);
    readChk("R13 sec", 3'd1, 8'h00);
    readChk("R13 min", 3'd2, 8'h00);
    readChk("R13 hour", 3'd3, 8'h00);
    readChk("R13 day", 3'd4, 8'h01);
    readChk("R13 date", 3'd5, 8'h01);
    readChk("R13 month", 3'd6, 8'h01);
    readChk("R13 year", 3'd7, 8'h00);
    check("R13 freqOut", {7'd0, freqOut}, 8'h00);

    // R6 counting run from midnight
    setTime(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    for (int i = 1; i <= 3661; i++) begin
      second();
      if (i <= 121) begin
        readChk("R6 sec", 3'd1, bcd(i % 60));
        readChk("R6 min", 3'd2, bcd(i / 60));
      end
    end
    readChk("R6 hour after run", 3'd3, 8'h01);
    readChk("R6 min after run", 3'd2, 8'h01);
    readChk("R6 sec after run", 3'd1, 8'h01);

    // R9 stop bit
    busWrite(3'd1, 8'h80);
    for (int i = 0; i < 6; i++) tickOnce();
    readChk("R9 stopped sec", 3'd1, 8'h81);
    busWrite(3'd1, 8'h00);
    readChk("R9 restart sec", 3'd1, 8'h01);
    second();
    readChk("R9 running sec", 3'd1, 8'h02);

    // R10 clock-field write without hold is ignored; R5 spare accepted
    busWrite(3'd2, 8'h45);
    readChk("R10 ignored min", 3'd2, 8'h01);
    busWrite(3'd2, 8'hB0);
    readChk("R5 min spare", 3'd2, 8'h81);
    busWrite(3'd2, 8'h00);

    // R10 write hold
    busWrite(3'd0, 8'h80);
    second(); second();
    readChk("R10 suspended sec", 3'd1, 8'h02);
    readChk("R10 control byte", 3'd0, 8'h80);
    busWrite(3'd1, 8'h33);
    busWrite(3'd3, 8'hC7);
    readChk("R10 staged not live", 3'd1, 8'h02);
    busWrite(3'd0, 8'h00);
    readChk("R10 loaded sec", 3'd1, 8'h33);
    readChk("R10 loaded hour", 3'd3, 8'hC7);

    // R11 read hold
    busWrite(3'd0, 8'h40);
    readChk("R11 control byte", 3'd0, 8'h40);
    second(); second(); second();
    readChk("R11 frozen sec", 3'd1, 8'h33);
    busWrite(3'd0, 8'h00);
    readChk("R11 released sec", 3'd1, 8'h36);

    // R3 capture data of last active cycle
    busWrite(3'd0, 8'h80);
    @(negedge clk);
    addr = {5'h1F, 3'd7}; dataIn = 8'h11; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); dataIn = 8'h22;
    @(negedge clk); dataIn = 8'h47;
    @(negedge clk); ceN = 1'b1; dataIn = 8'h99;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    busWrite(3'd0, 8'h00);
    readChk("R3 year end-of-write", 3'd7, 8'h47);

    // R5 spare bits in month and date
    busWrite(3'd0, 8'h80);
    busWrite(3'd6, 8'hA5);
    busWrite(3'd5, 8'hD5);
    busWrite(3'd0, 8'h00);
    readChk("R5 month spare", 3'd6, 8'hA5);
    readChk("R5 date spare", 3'd5, 8'hD5);

    // R5 battery flag read-only
    batFlag = 1'b1;
    readChk("R5 battery set", 3'd4, 8'h81);
    busWrite(3'd4, 8'h00);
    readChk("R5 battery write ignored", 3'd4, 8'h81);
    batFlag = 1'b0;
    readChk("R5 battery clear", 3'd4, 8'h01);

    // R12 frequency test
    busWrite(3'd4, 8'h40);
    readChk("R12 ft bit", 3'd4, 8'h41);
    #1 check("R12 first half", {7'd0, freqOut}, 8'h01);
    tickOnce();
    #1 check("R12 second half", {7'd0, freqOut}, 8'h00);
    tickOnce();
    #1 check("R12 next second", {7'd0, freqOut}, 8'h01);
    busWrite(3'd1, 8'h80);
    #1 check("R12 stopped", {7'd0, freqOut}, 8'h00);
    busWrite(3'd1, 8'h00);
    busWrite(3'd4, 8'h00);
    #1 check("R12 ft clear", {7'd0, freqOut}, 8'h00);

    // R1 / R2 / R4 bus behaviour
    @(negedge clk);
    addr = 8'h10; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1 check("R1 miss no drive", {7'd0, dataOe}, 8'h00);
    addr = {5'h1F, 3'd7};
    #1 check("R2 hit drives", {7'd0, dataOe}, 8'h01);
    check("R2 read data", dataOut, 8'h47);
    oeN = 1'b1;
    #1 check("R2 oe high no drive", {7'd0, dataOe}, 8'h00);
    oeN = 1'b0; dataIn = 8'h47; weN = 1'b0;
    #1 check("R4 released in write", {7'd0, dataOe}, 8'h00);
    @(negedge clk);
    weN = 1'b1;
    #1 check("R4 drives after write", {7'd0, dataOe}, 8'h01);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);

    // R7 / R8 month-end sweep
    for (int yi = 0; yi < 4; yi++) begin
      for (int mi = 1; mi <= 12; mi++) begin
        y = yrs[yi]; m = mi; dd = daysOf(m, y);
        setTime(8'h05, bcd(y), bcd(m), bcd(dd), 8'h03, 8'h23, 8'h59, 8'h59);
        second();
        readChk("R7 date wrap", 3'd5, 8'h01);
        readChk("R7 day step", 3'd4, 8'h04);
        readChk("R8 month", 3'd6, bcd((m % 12) + 1));
        readChk("R8 year", 3'd7, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
        readChk("R8 century", 3'd0, (m == 12 && y == 99) ? 8'h06 : 8'h05);
        readChk("R6 hour wrap", 3'd3, 8'h00);
      end
    end

    // R7 leap day and day-of-week wrap
    setTime(8'h00, 8'h04, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    second();
    readChk("R7 leap 29th", 3'd5, 8'h29);
    readChk("R7 leap month", 3'd6, 8'h02);
    readChk("R7 day 7 to 1", 3'd4, 8'h01);

    // R8 century 39 wrap
    setTime(8'h39, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    second();
    readChk("R8 century wrap", 3'd0, 8'h00);
    readChk("R8 year wrap", 3'd7, 8'h00);
    readChk("R8 month wrap", 3'd6, 8'h01);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule